// File: doc/BRIEF.md
# Sequentially Consistent Shared-Memory Switch

This block is the front end of a small shared memory used by several processor ports. Each port offers one load or store at a time, in its own program order, over a valid/ready request channel. The switch picks one waiting port and takes its operation through the full memory latency. It returns a one-cycle completion pulse, with read data for loads. Only after that pulse does it pick another port.

Only one operation is ever in flight. Every port therefore sees a single global order of all loads and stores, and the write-to-read, read-to-read, read-to-write and write-to-write orderings are all kept. Stores take a configurable latency that may be very long, and loads take a separate configurable latency. While an operation is pending, no request from any port is accepted. Ports are served round-robin, so none of them starves. The storage is a small internal register file that is cleared at reset.

Top module: `sc_mem_switch`

## Requirements
- R1: After reset the switch is idle: no port sees ready, no done pulse is raised, and every memory word reads as zero.
- R2: Ready is raised for at most one port. It is raised only for a port whose valid is high, and only in the single cycle in which that port is granted.
- R3: When several ports are waiting, the grant goes to the first waiting port after the last granted one, in ascending index order with wrap-around. Port 0 has first turn after reset.
- R4: A store (write enable 1) completes with a done pulse exactly WR_LAT+1 cycles after its grant cycle. Every load granted after that pulse returns the stored value.
- R5: A load (write enable 0) completes with a done pulse exactly RD_LAT+1 cycles after its grant cycle, and the read data bus then carries the addressed word.
- R6: From a grant up to and including its done pulse, no port is granted, even when ports hold their valid high.
- R7: The done pulse lasts one cycle, goes only to the port that was granted, and is one-hot across ports.
- R8: Loads and stores from all ports take effect in grant order. A load granted after a store to the same address sees that store, and a load granted before it sees the old value, also when both requests arrived in the same cycle.
- R9: On a store's done pulse the read data bus is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPORTS | Per-port request valid |
| req_ready | output | NPORTS | Per-port grant, high in the grant cycle only |
| req_addr | input | NPORTS*AW | Per-port word address, port p at bits [p*AW +: AW] |
| req_wdata | input | NPORTS*DW | Per-port store data, port p at bits [p*DW +: DW] |
| req_we | input | NPORTS | Per-port operation: 1 store, 0 load |
| rsp_done | output | NPORTS | Per-port one-cycle completion pulse |
| rsp_data | output | DW | Load data, valid with a done pulse (zero for stores) |

## Verification
Two things can arrive in the same cycle: a store from one port and a load from another, both aimed at the same word. The bench raises both requests on one edge. It does this once with the storing port next in round-robin turn, and once with the loading port next. It then judges the load data against the grant order it predicts on its own: the new value when the store wins, and the old value when the load wins, which a follow-up load then confirms. A second overlap, where a port holds its request high while a long store is pending, is judged by comparing the cycle of its grant with the cycle of the earlier done pulse.

// File: rtl/sc_switch_pkg.sv
package sc_switch_pkg;

    // Sequencer phases of the switch
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,  // waiting to grant
        PH_WAIT = 2'd1,  // memory latency running
        PH_DONE = 2'd2   // completion pulse cycle
    } phase_e;

endpackage

// File: rtl/sc_rr_pick.sv
module sc_rr_pick #(
    parameter int NPORTS = 4,
    localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic              en,
    input  logic [NPORTS-1:0] req,
    input  logic [PW-1:0]     last,
    output logic              pick_vld,
    output logic [PW-1:0]     pick_idx
);

    // Scan starting one past the previous winner, wrapping around.
    always_comb begin
        int idx;
        pick_vld = 1'b0;
        pick_idx = '0;
        idx      = 0;
        for (int k = 1; k <= NPORTS; k++) begin
            idx = (int'(last) + k) % NPORTS;
            if (en && !pick_vld && req[idx]) begin
                pick_vld = 1'b1;
                pick_idx = PW'(idx);
            end
        end
    end

endmodule

// File: rtl/sc_word_store.sv
module sc_word_store #(
    parameter int AW = 4,
    parameter int DW = 16,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] words [DEPTH];

    // One register per word, cleared by reset.
    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[w] <= '0;
            end else if (wr_en && (addr == AW'(w))) begin
                words[w] <= wr_data;
            end
        end
    end

    assign rd_data = words[addr];

endmodule

// File: rtl/sc_mem_switch.sv
module sc_mem_switch
    import sc_switch_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int AW     = 4,
    parameter int DW     = 16,
    parameter int WR_LAT = 100,
    parameter int RD_LAT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPORTS-1:0]    req_valid,
    output logic [NPORTS-1:0]    req_ready,
    input  logic [NPORTS*AW-1:0] req_addr,
    input  logic [NPORTS*DW-1:0] req_wdata,
    input  logic [NPORTS-1:0]    req_we,
    output logic [NPORTS-1:0]    rsp_done,
    output logic [DW-1:0]        rsp_data
);

    localparam int PW     = (NPORTS > 1) ? $clog2(NPORTS) : 1;
    localparam int MAXLAT = (WR_LAT > RD_LAT) ? WR_LAT : RD_LAT;
    localparam int CW     = $clog2(MAXLAT + 1);

    typedef struct packed {
        phase_e        ph;
        logic [PW-1:0] owner;
        logic [PW-1:0] last;
        logic          is_wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [CW-1:0] left;
        logic [DW-1:0] rdata;
    } sw_state_t;

    sw_state_t s_d, s_q;

    logic          pick_vld;
    logic [PW-1:0] pick_idx;
    logic          mem_wr;
    logic [DW-1:0] mem_rd;

    sc_rr_pick #(.NPORTS(NPORTS)) u_pick (
        .en       (s_q.ph == PH_IDLE),
        .req      (req_valid),
        .last     (s_q.last),
        .pick_vld (pick_vld),
        .pick_idx (pick_idx)
    );

    sc_word_store #(.AW(AW), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mem_wr),
        .addr    (s_q.addr),
        .wr_data (s_q.wdata),
        .rd_data (mem_rd)
    );

    always_comb begin
        s_d       = s_q;
        mem_wr    = 1'b0;
        req_ready = '0;
        rsp_done  = '0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (pick_vld) begin
                    req_ready[pick_idx] = 1'b1;
                    s_d.owner = pick_idx;
                    s_d.last  = pick_idx;
                    s_d.is_wr = req_we[pick_idx];
                    s_d.addr  = req_addr[pick_idx*AW +: AW];
                    s_d.wdata = req_wdata[pick_idx*DW +: DW];
                    s_d.left  = req_we[pick_idx] ? CW'(WR_LAT - 1) : CW'(RD_LAT - 1);
                    s_d.ph    = PH_WAIT;
                end
            end
            PH_WAIT: begin
                if (s_q.left == '0) begin
                    // Latency spent: commit store or capture load data.
                    mem_wr    = s_q.is_wr;
                    s_d.rdata = s_q.is_wr ? '0 : mem_rd;
                    s_d.ph    = PH_DONE;
                end else begin
                    s_d.left = s_q.left - 1'b1;
                end
            end
            PH_DONE: begin
                rsp_done[s_q.owner] = 1'b1;
                s_d.ph = PH_IDLE;
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, last: PW'(NPORTS - 1), default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_data = s_q.rdata;

endmodule

// File: rtl/sc_mem_switch_chk.sv
module sc_mem_switch_chk #(
    parameter int NPORTS = 4,
    parameter int DW     = 16,
    parameter int WR_LAT = 100,
    parameter int RD_LAT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NPORTS-1:0] req_valid,
    input logic [NPORTS-1:0] req_ready,
    input logic [NPORTS-1:0] req_we,
    input logic [NPORTS-1:0] rsp_done,
    input logic [DW-1:0]     rsp_data
);

    localparam int MAXLAT = (WR_LAT > RD_LAT) ? WR_LAT : RD_LAT;
    localparam int TW     = $clog2(MAXLAT + 2) + 1;
    localparam logic [TW-1:0] WR_T = TW'(WR_LAT);
    localparam logic [TW-1:0] RD_T = TW'(RD_LAT);

    logic              busy_q;
    logic              wr_q;
    logic [NPORTS-1:0] own_q;
    logic [TW-1:0]     age_q;

    // Observer: tracks the outstanding operation from the port side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            wr_q   <= 1'b0;
            own_q  <= '0;
            age_q  <= '0;
        end else if (|req_ready) begin
            busy_q <= 1'b1;
            wr_q   <= |(req_ready & req_we);
            own_q  <= req_ready;
            age_q  <= '0;
        end else if (|rsp_done) begin
            busy_q <= 1'b0;
        end else if (busy_q && (age_q != '1)) begin
            age_q <= age_q + 1'b1;
        end
    end

    p_ready_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));

    p_ready_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == '0);

    p_no_grant_in_flight_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (req_ready == '0));

    p_done_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_done));

    p_done_to_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|rsp_done) |-> (busy_q && (rsp_done == own_q)));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|rsp_done) |=> (rsp_done == '0));

    p_store_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|rsp_done) && wr_q) |-> (age_q == WR_T));

    p_load_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|rsp_done) && !wr_q) |-> (age_q == RD_T));

    p_store_data_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|rsp_done) && wr_q) |-> (rsp_data == '0));

endmodule

bind sc_mem_switch sc_mem_switch_chk #(
    .NPORTS (NPORTS),
    .DW     (DW),
    .WR_LAT (WR_LAT),
    .RD_LAT (RD_LAT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_we    (req_we),
    .rsp_done  (rsp_done),
    .rsp_data  (rsp_data)
);

// File: tb/tb_sc_mem_switch.sv
`timescale 1ns/1ps
module tb_sc_mem_switch;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int WR_LAT = 100;
    localparam int RD_LAT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0]    req_valid = '0;
    logic [NP-1:0]    req_ready;
    logic [NP*AW-1:0] req_addr = '0;
    logic [NP*DW-1:0] req_wdata = '0;
    logic [NP-1:0]    req_we = '0;
    logic [NP-1:0]    rsp_done;
    logic [DW-1:0]    rsp_data;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int viol = 0;
    bit busy_tb = 0;

    sc_mem_switch #(.NPORTS(NP), .AW(AW), .DW(DW), .WR_LAT(WR_LAT), .RD_LAT(RD_LAT)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_we(req_we),
        .rsp_done(rsp_done), .rsp_data(rsp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Port-side monitor of grant exclusivity and done one-hotness.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                if (busy_tb && (|req_ready)) viol++;
                if ($countones(rsp_done) > 1) viol++;
                if (|rsp_done) busy_tb = 0;
                if (|req_ready) busy_tb = 1;
            end
        end
    end

    // One operation from port p; returns data, grant cycle, done cycle, latency.
    task automatic op(input int p, input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      output logic [DW-1:0] rd, output int gcyc, output int dcyc, output int lat);
        @(negedge clk);
        req_we[p] = we;
        req_addr[p*AW +: AW] = a;
        req_wdata[p*DW +: DW] = d;
        req_valid[p] = 1'b1;
        forever begin
            #1;
            if (req_ready[p]) break;
            @(negedge clk);
        end
        gcyc = cyc;
        @(negedge clk);
        req_valid[p] = 1'b0;
        lat = 1;
        forever begin
            #1;
            if (rsp_done[p]) break;
            @(negedge clk);
            lat++;
        end
        dcyc = cyc;
        rd = rsp_data;
        @(negedge clk);
        #1;
        check(rsp_done[p] == 1'b0, "R7 done lasts one cycle", int'(rsp_done), 0);
    endtask

    task automatic t_reset();
        logic [DW-1:0] rd;
        int g, dc, l;
        #1;
        check(req_ready == '0, "R1 no ready after reset", int'(req_ready), 0);
        check(rsp_done == '0, "R1 no done after reset", int'(rsp_done), 0);
        op(0, 1'b0, 4'h5, '0, rd, g, dc, l);
        check(rd == '0, "R1 cleared word reads zero", int'(rd), 0);
        check(l == RD_LAT + 1, "R5 load latency", l, RD_LAT + 1);
    endtask

    task automatic t_store_load();
        logic [DW-1:0] rd;
        int g, dc, l;
        op(1, 1'b1, 4'h3, 16'hA5A5, rd, g, dc, l);
        check(l == WR_LAT + 1, "R4 store latency", l, WR_LAT + 1);
        check(rd == '0, "R9 store response data zero", int'(rd), 0);
        op(2, 1'b0, 4'h3, '0, rd, g, dc, l);
        check(rd == 16'hA5A5, "R4 load sees earlier store", int'(rd), 16'hA5A5);
        check(l == RD_LAT + 1, "R5 load latency", l, RD_LAT + 1);
    endtask

    task automatic t_round_robin();
        // Last grant was port 2, so order must be 3,0,1,2.
        logic [DW-1:0] rd [NP];
        int g [NP];
        int dc [NP];
        int l [NP];
        fork
            op(0, 1'b0, 4'h3, '0, rd[0], g[0], dc[0], l[0]);
            op(1, 1'b0, 4'h3, '0, rd[1], g[1], dc[1], l[1]);
            op(2, 1'b0, 4'h3, '0, rd[2], g[2], dc[2], l[2]);
            op(3, 1'b0, 4'h3, '0, rd[3], g[3], dc[3], l[3]);
        join
        check(g[3] < g[0], "R3 port 3 before port 0", g[3], g[0]);
        check(g[0] < g[1], "R3 port 0 before port 1", g[0], g[1]);
        check(g[1] < g[2], "R3 port 1 before port 2", g[1], g[2]);
        for (int p = 0; p < NP; p++)
            check(rd[p] == 16'hA5A5, "R5 load data under contention", int'(rd[p]), 16'hA5A5);
    endtask

    task automatic t_write_write();
        logic [DW-1:0] rd;
        int g, dc, l;
        op(0, 1'b1, 4'h7, 16'h0001, rd, g, dc, l);
        op(0, 1'b1, 4'h7, 16'h0002, rd, g, dc, l);
        op(0, 1'b0, 4'h7, '0, rd, g, dc, l);
        check(rd == 16'h0002, "R8 later store wins", int'(rd), 2);
    endtask

    task automatic t_race();
        logic [DW-1:0] rw, rr;
        int gw, gr, dw, dr, lw, lr;
        // Last grant port 0: port 1 store goes before port 2 load.
        fork
            op(1, 1'b1, 4'h9, 16'h1234, rw, gw, dw, lw);
            op(2, 1'b0, 4'h9, '0, rr, gr, dr, lr);
        join
        check(gw < gr, "R3 store port granted first", gw, gr);
        check(rr == 16'h1234, "R8 same-cycle load after store", int'(rr), 16'h1234);
        // Last grant port 2: port 3 load goes before port 2 store.
        fork
            op(3, 1'b0, 4'hA, '0, rr, gr, dr, lr);
            op(2, 1'b1, 4'hA, 16'hBEEF, rw, gw, dw, lw);
        join
        check(gr < gw, "R3 load port granted first", gr, gw);
        check(rr == '0, "R8 load before store sees old", int'(rr), 0);
        op(0, 1'b0, 4'hA, '0, rr, gr, dr, lr);
        check(rr == 16'hBEEF, "R8 store visible afterwards", int'(rr), 16'hBEEF);
    endtask

    task automatic t_hold_off();
        logic [DW-1:0] rw, rr;
        int gw, gr, dw, dr, lw, lr;
        fork
            op(0, 1'b1, 4'hB, 16'h0077, rw, gw, dw, lw);
            begin
                repeat (2) @(negedge clk);
                op(1, 1'b0, 4'hB, '0, rr, gr, dr, lr);
            end
        join
        check(gr > dw, "R6 waiting port granted after done", gr, dw);
        check(rr == 16'h0077, "R8 held load sees pending store", int'(rr), 16'h77);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_store_load();
        t_round_robin();
        t_write_write();
        t_race();
        t_hold_off();
        check(viol == 0, "R6 R7 monitor grant and done exclusivity", viol, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule